// File: doc/BRIEF.md
# Comma-Synchronised Byte Scrambler and Descrambler

This block whitens a byte-wide character stream before it reaches an 8b/10b encoder, and restores it after the decoder on the far side. Long runs of idle or constant payload, all zeros for example, would otherwise give a receive equaliser a strongly correlated bit pattern to adapt to. Every payload byte is XORed with eight bits of a 16-bit pseudo-random keystream. The matching receive lane applies the same keystream, and the XOR recovers the original byte.

Both directions sit side by side in one top module. Each direction takes a byte, a control flag and a valid strobe per clock, and returns the same three signals one cycle later. Control characters go through unchanged. The comma control character (flag 1, byte 0xBC) puts the keystream generator back to its seed on whichever side sees it. Because the transmitter sends that comma and the receiver receives it at the same point in the character stream, both generators line up without a separate training exchange.

Top module: `comma_sync_scrambler`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, every output valid, control flag and data byte is 0. Each keystream generator starts from state 0xFFFF.
- R2: Each direction has a latency of exactly one cycle: out valid equals in valid from the previous cycle.
- R3: One keystream step emits state bit 15. The state then shifts left by one and bit 0 takes bit15 ^ bit4 ^ bit3 ^ bit2 (polynomial x^16+x^5+x^4+x^3+1). The state is never zero.
- R4: A valid byte with control flag 0 is output with bit i (i = 0 for the LSB first) XORed with the output of step i. This takes eight steps per byte.
- R5: A valid byte with control flag 1 that is not 0xBC is output unchanged with flag 1, and the keystream still advances eight steps.
- R6: A valid comma (flag 1, byte 0xBC) is output unchanged with flag 1, and the keystream state becomes 0xFFFF for the next byte.
- R7: When in valid is 0, the keystream state holds and the output is valid 0, flag 0 and data 0, whatever the data and flag inputs carry.
- R8: With the transmit output looped into the receive input, every byte and flag sent after a comma comes out of the receive lane unchanged, two cycles after it entered.
- R9: The two directions are independent: traffic on one never changes the keystream or the outputs of the other.
- R10: A data byte equal to 0xBC with flag 0 is scrambled like any other data byte and does not reseed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both directions |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_in_vld | input | 1 | Transmit character strobe |
| tx_in_data | input | 8 | Transmit byte before scrambling |
| tx_in_ctl | input | 1 | Transmit control-character flag |
| tx_out_vld | output | 1 | Scrambled character strobe |
| tx_out_data | output | 8 | Scrambled byte |
| tx_out_ctl | output | 1 | Control flag of the scrambled character |
| rx_in_vld | input | 1 | Receive character strobe |
| rx_in_data | input | 8 | Received scrambled byte |
| rx_in_ctl | input | 1 | Receive control-character flag |
| rx_out_vld | output | 1 | Descrambled character strobe |
| rx_out_data | output | 8 | Descrambled byte |
| rx_out_ctl | output | 1 | Control flag of the descrambled character |

## Verification
The assertions take for granted that no input is unknown while reset is released. They also take for granted that the result of a character is only judged from the first cycle after reset onward, which a one-bit "running" register guards. The round-trip property R8 assumes that the stream sent into the receive lane starts with a comma. Before that comma the two keystreams are unrelated. The stimulus therefore keeps both lanes idle for a few cycles before it closes the loop, and makes the first transmitted character of the looped phase a comma. Only characters from that comma onward are compared with what was sent. Outside the looped phase, the data and flag inputs carry random values even on idle cycles, to show that R7 holds.

// File: rtl/scr_pkg.sv
package scr_pkg;

  localparam int          BYTE_W     = 8;
  localparam int          LFSR_W     = 16;
  localparam logic [15:0] LFSR_SEED  = 16'hFFFF;
  // feedback taps below the top bit: x^5, x^4, x^3 terms -> bits 4,3,2
  localparam logic [15:0] TAP_MASK   = 16'h001C;
  localparam logic [7:0]  COMMA_CODE = 8'hBC;
  localparam int          N_LANES    = 2;

  typedef logic [LFSR_W-1:0] lfsr_t;
  typedef logic [BYTE_W-1:0] byte_t;

  // one keystream step: shift left, feedback into bit 0
  function automatic lfsr_t lfsr_step(input lfsr_t s);
    logic fb;
    fb = s[LFSR_W-1] ^ (^(s & TAP_MASK));
    return {s[LFSR_W-2:0], fb};
  endfunction

  // keystream bits for one byte, LSB consumed first
  function automatic byte_t keystream_byte(input lfsr_t s);
    byte_t ks;
    lfsr_t t;
    t = s;
    for (int i = 0; i < BYTE_W; i++) begin
      ks[i] = t[LFSR_W-1];
      t     = lfsr_step(t);
    end
    return ks;
  endfunction

  // state after one byte worth of steps
  function automatic lfsr_t lfsr_advance(input lfsr_t s);
    lfsr_t t;
    t = s;
    for (int i = 0; i < BYTE_W; i++) t = lfsr_step(t);
    return t;
  endfunction

endpackage

// File: rtl/scr_char_classify.sv
module scr_char_classify
  import scr_pkg::*;
#(
  parameter byte_t COMMA = COMMA_CODE
) (
  input  logic  in_vld,
  input  byte_t in_data,
  input  logic  in_ctl,
  output logic  is_comma,
  output logic  is_ctl_other,
  output logic  is_data
);

  always_comb begin
    is_comma     = in_vld &&  in_ctl && (in_data == COMMA);
    is_ctl_other = in_vld &&  in_ctl && (in_data != COMMA);
    is_data      = in_vld && !in_ctl;
  end

endmodule

// File: rtl/scr_lfsr_core.sv
module scr_lfsr_core
  import scr_pkg::*;
#(
  parameter lfsr_t SEED = LFSR_SEED
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv,
  input  logic  reseed,
  output lfsr_t state,
  output byte_t ks
);

  lfsr_t state_q;
  logic  live_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEED;
      live_q  <= 1'b0;
    end else begin
      live_q <= 1'b1;
      if (reseed)   state_q <= SEED;
      else if (adv) state_q <= lfsr_advance(state_q);
    end
  end

  assign state = state_q;
  assign ks    = keystream_byte(state_q);

  AST_LFSR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && $past(!adv && !reseed)) |-> $stable(state_q)); // R7

  AST_LFSR_RESEED: assert property (@(posedge clk) disable iff (!rst_n)
    reseed |=> (state_q == SEED)); // R6

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0); // R3

endmodule

// File: rtl/scr_lane.sv
module scr_lane
  import scr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_vld,
  input  byte_t in_data,
  input  logic  in_ctl,
  output logic  out_vld,
  output byte_t out_data,
  output logic  out_ctl
);

  logic  is_comma, is_ctl_other, is_data;
  lfsr_t state;
  byte_t ks;
  logic  live_q;

  scr_char_classify #(.COMMA(COMMA_CODE)) u_class (
    .in_vld       (in_vld),
    .in_data      (in_data),
    .in_ctl       (in_ctl),
    .is_comma     (is_comma),
    .is_ctl_other (is_ctl_other),
    .is_data      (is_data)
  );

  scr_lfsr_core #(.SEED(LFSR_SEED)) u_lfsr (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv    (is_data || is_ctl_other),
    .reseed (is_comma),
    .state  (state),
    .ks     (ks)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_data <= '0;
      out_ctl  <= 1'b0;
      live_q   <= 1'b0;
    end else begin
      live_q  <= 1'b1;
      out_vld <= in_vld;
      if (in_vld) begin
        out_ctl  <= in_ctl;
        out_data <= is_data ? (in_data ^ ks) : in_data;
      end else begin
        out_ctl  <= 1'b0;
        out_data <= '0;
      end
    end
  end

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> (out_vld == $past(in_vld))); // R2

  AST_CTL_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_ctl) |=> (out_ctl && out_data == $past(in_data))); // R5

  AST_DATA_WHITENED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !in_ctl) |=> (!out_ctl && out_data == ($past(in_data) ^ $past(ks)))); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> (!out_vld && !out_ctl && out_data == '0)); // R7

  AST_STATE_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !is_comma) |=> (state == lfsr_advance($past(state)))); // R10

endmodule

// File: rtl/comma_sync_scrambler.sv
module comma_sync_scrambler
  import scr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_in_vld,
  input  logic [7:0] tx_in_data,
  input  logic       tx_in_ctl,
  output logic       tx_out_vld,
  output logic [7:0] tx_out_data,
  output logic       tx_out_ctl,
  input  logic       rx_in_vld,
  input  logic [7:0] rx_in_data,
  input  logic       rx_in_ctl,
  output logic       rx_out_vld,
  output logic [7:0] rx_out_data,
  output logic       rx_out_ctl
);

  // lane 0 = transmit scrambler, lane 1 = receive descrambler
  logic  [N_LANES-1:0] l_in_vld, l_in_ctl, l_out_vld, l_out_ctl;
  byte_t [N_LANES-1:0] l_in_data, l_out_data;

  assign l_in_vld  = {rx_in_vld,  tx_in_vld};
  assign l_in_ctl  = {rx_in_ctl,  tx_in_ctl};
  assign l_in_data = {rx_in_data, tx_in_data};

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    scr_lane u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_vld   (l_in_vld[g]),
      .in_data  (l_in_data[g]),
      .in_ctl   (l_in_ctl[g]),
      .out_vld  (l_out_vld[g]),
      .out_data (l_out_data[g]),
      .out_ctl  (l_out_ctl[g])
    );
  end

  assign tx_out_vld  = l_out_vld[0];
  assign tx_out_ctl  = l_out_ctl[0];
  assign tx_out_data = l_out_data[0];
  assign rx_out_vld  = l_out_vld[1];
  assign rx_out_ctl  = l_out_ctl[1];
  assign rx_out_data = l_out_data[1];

  AST_RX_QUIET_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_in_vld |=> !rx_out_vld); // R9

endmodule

// File: tb/comma_sync_scrambler_bench.sv
module comma_sync_scrambler_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk; // 50 MHz

  logic       tx_in_vld = 0, tx_in_ctl = 0;
  logic [7:0] tx_in_data = 0;
  logic       d_rx_vld = 0, d_rx_ctl = 0;
  logic [7:0] d_rx_data = 0;
  logic       loop_en = 0;
  logic       rx_in_vld, rx_in_ctl;
  logic [7:0] rx_in_data;
  logic       tx_out_vld, tx_out_ctl, rx_out_vld, rx_out_ctl;
  logic [7:0] tx_out_data, rx_out_data;

  assign rx_in_vld  = loop_en ? tx_out_vld  : d_rx_vld;
  assign rx_in_ctl  = loop_en ? tx_out_ctl  : d_rx_ctl;
  assign rx_in_data = loop_en ? tx_out_data : d_rx_data;

  comma_sync_scrambler u_comma_sync_scrambler (
    .clk(clk), .rst_n(rst_n),
    .tx_in_vld(tx_in_vld), .tx_in_data(tx_in_data), .tx_in_ctl(tx_in_ctl),
    .tx_out_vld(tx_out_vld), .tx_out_data(tx_out_data), .tx_out_ctl(tx_out_ctl),
    .rx_in_vld(rx_in_vld), .rx_in_data(rx_in_data), .rx_in_ctl(rx_in_ctl),
    .rx_out_vld(rx_out_vld), .rx_out_data(rx_out_data), .rx_out_ctl(rx_out_ctl)
  );

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  // reference model state (one keystream per direction)
  logic [15:0] m_st [2];
  logic        e_vld [2];
  logic        e_ctl [2];
  logic [7:0]  e_dat [2];
  logic [8:0]  sent_q [$];   // {ctl, data} sent during loopback
  string       phase_tag = "R1";

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural model of one character through one direction
  task automatic model(input int l, input logic v, input logic [7:0] d, input logic c);
    logic [15:0] s;
    logic [7:0]  o;
    s = m_st[l];
    e_vld[l] = v;
    e_ctl[l] = v ? c : 1'b0;
    e_dat[l] = 8'h00;
    if (v) begin
      if (c && d == 8'hBC) begin
        e_dat[l] = d;
        s = 16'hFFFF;
      end else begin
        o = 8'h00;
        for (int k = 0; k < 8; k++) begin
          bit ksb, fb;
          ksb  = s[15];
          o[k] = d[k] ^ (c ? 1'b0 : ksb);
          fb   = s[15] ^ s[4] ^ s[3] ^ s[2];
          s    = {s[14:0], fb};
        end
        e_dat[l] = o;
      end
    end
    m_st[l] = s;
  endtask

  function automatic string kind_tag(input int l);
    if (!e_vld[l])                              return "R7";
    if (e_ctl[l] && e_dat[l] == 8'hBC)          return "R6";
    if (e_ctl[l])                               return "R5";
    return "R4";
  endfunction

  task automatic compare_outputs();
    logic [9:0] a0, x0, a1, x1;
    a0 = {tx_out_vld, tx_out_ctl, tx_out_data};
    x0 = {e_vld[0], e_ctl[0], e_dat[0]};
    a1 = {rx_out_vld, rx_out_ctl, rx_out_data};
    x1 = {e_vld[1], e_ctl[1], e_dat[1]};
    check(a0 == x0, {"tx ", kind_tag(0), " R2 ", phase_tag}, {6'd0, a0}, {6'd0, x0});
    check(a1 == x1, {"rx ", kind_tag(1), " R2 ", phase_tag}, {6'd0, a1}, {6'd0, x1});
    if (loop_en && rx_out_vld) begin
      logic [8:0] want;
      if (sent_q.size() == 0) check(0, "R8 unexpected byte", {7'd0, rx_out_ctl, rx_out_data}, 16'h0);
      else begin
        want = sent_q.pop_front();
        check({rx_out_ctl, rx_out_data} == want, "R8 round trip",
              {7'd0, rx_out_ctl, rx_out_data}, {7'd0, want});
      end
    end
  endtask

  // one cycle: check, then drive next inputs and predict
  task automatic step(input logic tv, input logic [7:0] td, input logic tc,
                      input logic rv, input logic [7:0] rd, input logic rc);
    compare_outputs();
    tx_in_vld = tv; tx_in_data = td; tx_in_ctl = tc;
    d_rx_vld  = rv; d_rx_data  = rd; d_rx_ctl  = rc;
    if (loop_en && tv) sent_q.push_back({tc, td});
    #1;
    model(0, tv, td, tc);
    model(1, rx_in_vld, rx_in_data, rx_in_ctl);
    @(negedge clk);
  endtask

  task automatic rnd_char(output logic v, output logic [7:0] d, output logic c, input int pv);
    int r;
    r = $urandom_range(0, 99);
    v = (r < pv);
    d = 8'($urandom);
    r = $urandom_range(0, 99);
    c = (r < 20);
    if (c && r < 10) d = 8'hBC;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R1-all actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic tv, tc, rv, rc;
    logic [7:0] td, rd;
    m_st[0] = 16'hFFFF; m_st[1] = 16'hFFFF;
    for (int l = 0; l < 2; l++) begin e_vld[l] = 0; e_ctl[l] = 0; e_dat[l] = 0; end
    // R1: outputs quiet under reset, even with inputs toggling
    repeat (3) @(negedge clk);
    tx_in_vld = 1; tx_in_data = 8'h5A; d_rx_vld = 1; d_rx_data = 8'hA5;
    @(negedge clk);
    check({tx_out_vld, tx_out_ctl, tx_out_data, rx_out_vld, rx_out_ctl, rx_out_data} == 20'h0,
          "R1 reset outputs", {tx_out_vld, tx_out_ctl, 6'd0, tx_out_data}, 16'h0);
    tx_in_vld = 0; d_rx_vld = 0;
    rst_n = 1;
    @(negedge clk);

    // R3/R4/R9: all-zero payload on tx from the seed, rx idle with noise
    phase_tag = "R3 R9 zeros";
    for (int n = 0; n < 40; n++) step(1, 8'h00, 0, 0, 8'($urandom), 1'($urandom));

    // R10: data 0xBC (flag 0) never reseeds
    phase_tag = "R10";
    for (int n = 0; n < 20; n++) step(1, 8'hBC, 0, 1, 8'hBC, 0);

    // R6: comma then zeros restarts the keystream
    phase_tag = "R6 reseed";
    step(1, 8'hBC, 1, 1, 8'hBC, 1);
    for (int n = 0; n < 10; n++) step(1, 8'h00, 0, n[0], 8'h00, 0);

    // R7: idle gaps with garbage on the data and flag inputs
    phase_tag = "R7 idle";
    for (int n = 0; n < 30; n++) step(1'(n % 3 == 0), 8'($urandom), 1'($urandom & 1), 0, 8'($urandom), 1'($urandom & 1));

    // mixed traffic, both lanes independent
    phase_tag = "R5 R9 mix";
    for (int n = 0; n < 3000; n++) begin
      rnd_char(tv, td, tc, 75);
      rnd_char(rv, rd, rc, 60);
      step(tv, td, tc, rv, rd, rc);
    end

    // R8: loopback, first character a comma
    phase_tag = "R8 loop";
    for (int n = 0; n < 3; n++) step(0, 8'h00, 0, 0, 8'h00, 0);
    loop_en = 1;
    step(1, 8'hBC, 1, 0, 8'h00, 0);
    for (int n = 0; n < 3000; n++) begin
      rnd_char(tv, td, tc, 80);
      if (n % 97 == 0) begin td = 8'h00; tc = 0; end
      step(tv, td, tc, 0, 8'h00, 0);
    end
    for (int n = 0; n < 4; n++) step(0, 8'h00, 0, 0, 8'h00, 0);
    check(sent_q.size() == 0, "R8 all bytes returned", 16'(sent_q.size()), 16'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule